// File: doc/BRIEF.md
# Posted and Blocking Write Bridge

This block connects a simple CPU access port to a narrow remote target that runs a valid/ready request channel and a done pulse for completion. The CPU address carries an offset and one window bit above it. Both windows reach the same remote offsets. The window bit only decides how long the CPU is stalled, and it is never sent to the target.

In the blocking window, a write stalls the CPU until the target reports completion. In the posted window, a write is accepted at once, and the CPU goes on while the target works. A read is always blocking. A one-deep holding register keeps an access that arrives while an earlier transaction is still in flight. The CPU stays stalled until the earlier transaction is done. Transactions reach the target in program order, with at most one outstanding at a time.

CPU protocol: the CPU drives `cpu_sel` for one cycle, and only while `cpu_wait` is low. The access is accepted at that clock edge. When `cpu_wait` returns low, the access is finished, and for a read `cpu_rdata` is valid.

Top module: `pbw_bridge`

## Requirements
- R1: A write with address MSB = 0 (blocking window) raises `cpu_wait` in the cycle after acceptance. `cpu_wait` stays high until the edge that samples that write's own `tgt_done`, and falls right after that edge.
- R2: A write with address MSB = 1 (posted window), accepted while no transaction is outstanding, leaves `cpu_wait` low. The write is still sent to the target.
- R3: An access accepted while an earlier transaction is outstanding raises `cpu_wait`. It is issued to the target only after that earlier `tgt_done`. A posted write then releases `cpu_wait` right after the earlier done. A read issued behind a posted write returns the written value.
- R4: A read in either window raises `cpu_wait` until the edge that samples its `tgt_done`. After that, `cpu_rdata` holds the `tgt_rdata` value sampled with that done.
- R5: `tgt_off` equals the low `OFF_W` address bits, whatever the window bit. `tgt_write` = 1 for a write, and `tgt_data` carries the write data.
- R6: Requests reach the target in CPU program order, with at most one transaction between a valid/ready handshake and its done.
- R7: While `tgt_valid` is high and `tgt_ready` is low, `tgt_valid`, `tgt_off`, `tgt_data` and `tgt_write` stay unchanged.
- R8: After a synchronous reset, `cpu_wait` and `tgt_valid` are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Access strobe, accepted when `cpu_wait` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | OFF_W+1 | MSB selects the window (1 = posted), low bits give the offset |
| cpu_wdata | input | DATA_W | Write data |
| cpu_wait | output | 1 | Registered stall to the CPU |
| cpu_rdata | output | DATA_W | Data of the last completed read |
| tgt_valid | output | 1 | Request valid |
| tgt_ready | input | 1 | Target accepts the request |
| tgt_write | output | 1 | Request is a write |
| tgt_off | output | OFF_W | Remote offset |
| tgt_data | output | DATA_W | Write data to the target |
| tgt_done | input | 1 | One-cycle completion pulse |
| tgt_rdata | input | DATA_W | Read data, valid with `tgt_done` |

## Verification
The bench drives posted writes back-to-back. A design that ignored the outstanding transaction would leave the CPU running and would either drop the second write or issue it early. The bench drives a read straight after a posted write to the same offset. A design that reordered the two, or let the read overtake, would return stale data. Blocking accesses are checked so that the stall falls exactly one edge after their own done. A design that released on the handshake, or on an earlier posted write's done, fails that check. Both windows are used at offsets 0 and the top offset, which catches any leak of the window bit into `tgt_off`.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    typedef enum logic {
        WIN_BLOCK  = 1'b0,
        WIN_POSTED = 1'b1
    } win_e;

    // Only a posted-window write may let the CPU continue.
    function automatic logic needs_stall(input win_e win, input logic we);
        return !(win == WIN_POSTED && we);
    endfunction
endpackage

// File: rtl/pbw_decode.sv
module pbw_decode
    import pbw_pkg::*;
#(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic [OFF_W:0]    addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] dat,
    output logic              blk
);
    win_e win;

    always_comb begin
        win = win_e'(addr[OFF_W]);
        off = addr[OFF_W-1:0];
        dat = we ? wdata : '0;
        blk = needs_stall(win, we);
    end
endmodule

// File: rtl/pbw_ctrl.sv
module pbw_ctrl #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_sel,
    input  logic              acc_we,
    input  logic              acc_blk,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_dat,
    output logic              stall,
    output logic [DATA_W-1:0] rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [OFF_W-1:0]  req_off,
    output logic [DATA_W-1:0] req_data,
    input  logic              rsp_done,
    input  logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              we;
        logic              blk;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] dat;
    } cmd_t;

    typedef struct packed {
        logic              busy;
        logic              tv;
        logic              wt;
        cmd_t              cur;
        logic              pv;
        cmd_t              pend;
        logic [DATA_W-1:0] rd;
    } st_t;

    st_t  st_d, st_q;
    cmd_t in_cmd;
    logic accept, finish;

    always_comb begin
        in_cmd = '{we: acc_we, blk: acc_blk, off: acc_off, dat: acc_dat};
        accept = acc_sel && !st_q.wt;
        finish = st_q.busy && rsp_done;
        st_d   = st_q;

        if (st_q.tv && req_ready) begin
            st_d.tv = 1'b0;
        end

        if (finish) begin
            if (!st_q.cur.we) begin
                st_d.rd = rsp_data;
            end
            st_d.busy = 1'b0;
            st_d.wt   = 1'b0;
            if (st_q.pv) begin
                st_d.cur  = st_q.pend;
                st_d.busy = 1'b1;
                st_d.tv   = 1'b1;
                st_d.pv   = 1'b0;
                st_d.wt   = st_q.pend.blk;
            end
        end

        if (accept) begin
            if (!st_q.busy || finish) begin
                st_d.cur  = in_cmd;
                st_d.busy = 1'b1;
                st_d.tv   = 1'b1;
                st_d.wt   = in_cmd.blk;
            end else begin
                st_d.pend = in_cmd;
                st_d.pv   = 1'b1;
                st_d.wt   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall     = st_q.wt;
    assign rdata     = st_q.rd;
    assign req_valid = st_q.tv;
    assign req_write = st_q.cur.we;
    assign req_off   = st_q.cur.off;
    assign req_data  = st_q.cur.dat;
endmodule

// File: rtl/pbw_bridge.sv
module pbw_bridge #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [OFF_W:0]    cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_wait,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    output logic              tgt_write,
    output logic [OFF_W-1:0]  tgt_off,
    output logic [DATA_W-1:0] tgt_data,
    input  logic              tgt_done,
    input  logic [DATA_W-1:0] tgt_rdata
);
    logic [OFF_W-1:0]  dec_off;
    logic [DATA_W-1:0] dec_dat;
    logic              dec_blk;

    pbw_decode #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_dec (
        .addr  (cpu_addr),
        .we    (cpu_we),
        .wdata (cpu_wdata),
        .off   (dec_off),
        .dat   (dec_dat),
        .blk   (dec_blk)
    );

    pbw_ctrl #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acc_sel   (cpu_sel),
        .acc_we    (cpu_we),
        .acc_blk   (dec_blk),
        .acc_off   (dec_off),
        .acc_dat   (dec_dat),
        .stall     (cpu_wait),
        .rdata     (cpu_rdata),
        .req_valid (tgt_valid),
        .req_ready (tgt_ready),
        .req_write (tgt_write),
        .req_off   (tgt_off),
        .req_data  (tgt_data),
        .rsp_done  (tgt_done),
        .rsp_data  (tgt_rdata)
    );
endmodule

// File: rtl/pbw_bridge_chk.sv
module pbw_bridge_chk #(
    parameter int OFF_W  = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [OFF_W:0]    cpu_addr,
    input logic              cpu_wait,
    input logic              tgt_valid,
    input logic              tgt_ready,
    input logic              tgt_write,
    input logic [OFF_W-1:0]  tgt_off,
    input logic [DATA_W-1:0] tgt_data,
    input logic              tgt_done
);
    logic [1:0] inflight;
    logic       was_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 2'((tgt_valid && tgt_ready) ? 1 : 0)
                                 - 2'(tgt_done ? 1 : 0);
        end
        was_rst <= rst;
        if (was_rst) begin
            AST_RESET_QUIET: assert (!cpu_wait && !tgt_valid); // R8
        end
    end

    AST_BLOCK_WRITE_STALL: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_wait && cpu_we && !cpu_addr[OFF_W] |=> cpu_wait); // R1

    AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_wait && !cpu_we |=> cpu_wait); // R4

    AST_POSTED_FREE: assert property (@(posedge clk) disable iff (rst)
        cpu_sel && !cpu_wait && cpu_we && cpu_addr[OFF_W] && inflight == 2'd0 && !tgt_valid
        |=> !cpu_wait); // R2

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_wait) |-> $past(tgt_done)); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        inflight <= 2'd1 && (tgt_valid -> inflight == 2'd0 || tgt_done)); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_off) && $stable(tgt_data)
        && $stable(tgt_write)); // R7
endmodule

bind pbw_bridge pbw_bridge_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel   (cpu_sel),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wait  (cpu_wait),
    .tgt_valid (tgt_valid),
    .tgt_ready (tgt_ready),
    .tgt_write (tgt_write),
    .tgt_off   (tgt_off),
    .tgt_data  (tgt_data),
    .tgt_done  (tgt_done)
);

// File: tb/pbw_bridge_tb.sv
module pbw_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OW = 6;
    localparam int DW = 8;
    localparam int MAXT = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [OW:0]   cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_wait;
    logic [DW-1:0] cpu_rdata;
    logic          tgt_valid, tgt_write;
    logic          tgt_ready = 1'b0, tgt_done = 1'b0;
    logic [OW-1:0] tgt_off;
    logic [DW-1:0] tgt_data;
    logic [DW-1:0] tgt_rdata = '0;

    pbw_bridge #(.OFF_W(OW), .DATA_W(DW)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0, mismatched = 0, cyc = 0, issued = 0, tdone = 0;
    int done_at [MAXT];
    logic [DW-1:0] shadow [1<<OW];
    logic [DW-1:0] tmem   [1<<OW];
    logic [OW+DW:0] exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Target model and scoreboard monitor (R5, R6, R7)
    initial begin
        logic [OW+DW:0] got, exp;
        forever begin
            @(negedge clk);
            if (!rst && tgt_valid) begin
                got = {tgt_write, tgt_off, tgt_data};
                repeat ($urandom_range(0, 3)) begin
                    @(negedge clk);
                    chk({tgt_valid, tgt_write, tgt_off, tgt_data} == {1'b1, got}, "R7",
                        "request held", int'(tgt_off), int'(got[OW+DW-1:DW]));
                end
                tgt_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected request", int'(got), 0);
                end else begin
                    exp = exp_q.pop_front();
                    chk(got == exp, "R5 R6", "request order/content", int'(got), int'(exp));
                end
                if (tgt_write) tmem[tgt_off] = tgt_data;
                @(negedge clk);
                tgt_ready = 1'b0;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                tgt_rdata = tmem[got[OW+DW-1:DW]];
                tgt_done = 1'b1;
                done_at[tdone] = cyc + 1;
                tdone++;
                @(negedge clk);
                tgt_done = 1'b0;
                tgt_rdata = '0;
            end
        end
    end

    // CPU driver: one access, finished when the stall drops
    task automatic access(input bit post, input bit we, input int off, input logic [DW-1:0] d);
        int idx;
        bit blk, prev_busy;
        logic [DW-1:0] exp_rd;
        while (cpu_wait) @(negedge clk);
        idx = issued;
        cpu_sel = 1'b1; cpu_we = we; cpu_addr = {post, off[OW-1:0]}; cpu_wdata = d;
        exp_q.push_back({we, off[OW-1:0], we ? d : 8'h00});
        if (we) shadow[off] = d;
        exp_rd = shadow[off];
        issued++;
        @(negedge clk);
        cpu_sel = 1'b0;
        blk = !(post && we);
        prev_busy = (idx > 0) && !(tdone >= idx && done_at[idx-1] <= cyc);
        chk(cpu_wait == (blk || prev_busy), blk ? (we ? "R1" : "R4") : (prev_busy ? "R3" : "R2"),
            "stall after accept", int'(cpu_wait), int'(blk || prev_busy));
        if (cpu_wait) begin
            while (cpu_wait) @(negedge clk);
            if (blk)
                chk(tdone > idx && done_at[idx] == cyc, we ? "R1" : "R4",
                    "release after own done", cyc, done_at[idx]);
            else
                chk(done_at[idx-1] == cyc, "R3", "release after earlier done", cyc, done_at[idx-1]);
        end
        if (!we) chk(cpu_rdata == exp_rd, "R4 R3", "read data", int'(cpu_rdata), int'(exp_rd));
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << OW); i++) begin shadow[i] = '0; tmem[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_wait && !tgt_valid, "R8", "reset idle", int'({cpu_wait, tgt_valid}), 0);
        // back-to-back blocking writes, boundary offsets
        access(0, 1, 0, 8'h11);
        access(0, 1, (1 << OW) - 1, 8'hA5);
        // posted writes, chained
        access(1, 1, 5, 8'h21);
        access(1, 1, 6, 8'h22);
        access(1, 1, 7, 8'h23);
        // posted write then read of same offset through either window
        access(1, 1, 9, 8'h3C);
        access(0, 0, 9, 8'h00);
        access(1, 1, (1 << OW) - 1, 8'h5A);
        access(1, 0, (1 << OW) - 1, 8'h00);
        access(1, 0, 0, 8'h00);
        // posted then blocking write
        access(1, 1, 12, 8'h77);
        access(0, 1, 12, 8'h78);
        access(0, 0, 12, 8'h00);
        // random mix
        for (int n = 0; n < 300; n++) begin
            access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0),
                   $urandom_range(0, (1 << OW) - 1), 8'($urandom));
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        while (cpu_wait || tdone < issued) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "all requests issued", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule